// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block holds the working registers of an 8-bit processor core: six general registers (B, C, D, E, H, L), an accumulator A and a flag register F, each present twice. One copy of each register is active and the other is held in reserve. A single opcode swaps the whole general set with its reserve copy, and another swaps the accumulator/flag pair on its own. This gives an interrupt handler or a background task a private register context in one cycle. A third opcode exchanges the DE and HL pairs of the active set.

The block also executes register-to-register moves (`01dddsss`) and a single-register increment. No data is copied for a bank swap or a DE/HL exchange. Select flip-flops choose which physical copy is active, and a per-bank rename bit swaps the DE/HL pair. Every register of both sets is visible at all times on its own read port. A separate port lets the surrounding core load the active flag register.

Top module: `dualbank_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all sixteen register read ports and `op_err` to zero.
- R2: With `op_valid` high, opcode `01dddsss` copies the register named by sss into the register named by ddd. The register codes are 000=B, 001=C, 010=D, 011=E, 100=H, 101=L and 111=A.
- R3: Opcode 0xD9 exchanges all six active general registers with their reserve copies in one cycle. A and F are left as they are.
- R4: Opcode 0x08 exchanges the active A and F with their reserve copies in one cycle. The general registers are left as they are.
- R5: Opcode 0xEB exchanges D with H and E with L in the active set only. The reserve set keeps its values and its own pairing, including across later 0xD9 swaps.
- R6: Opcode `00rrr100` adds one, modulo 256, to the register with code rrr.
- R7: An increment updates the active F as follows: bit 7 receives bit 7 of the result, bit 6 is set when the result is zero, and bit 2 is set only when the operand was 0x7F. All other F bits, including the carry bit 0, keep their values.
- R8: Register code 110 in any field of a move or increment, and any opcode other than those above and 0x00 (no operation), is illegal. An illegal opcode changes no register and raises `op_err` for exactly the following cycle.
- R9: When `op_valid` is low and `flag_we` is high, the active F is loaded with `flag_wdata`. While `op_valid` is high, `flag_we` is ignored.
- R10: While `op_valid` is low, `op_code` has no effect on any register.
- R11: The result of an operation applied at a rising edge appears on the read ports directly after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Execute `op_code` at this edge |
| op_code | input | 8 | Operation to execute |
| flag_we | input | 1 | Load active F from `flag_wdata` (only with `op_valid` low) |
| flag_wdata | input | 8 | Flag value to load |
| op_err | output | 1 | Previous operation was illegal |
| reg_a | output | 8 | Active accumulator |
| reg_f | output | 8 | Active flags |
| reg_b | output | 8 | Active B |
| reg_c | output | 8 | Active C |
| reg_d | output | 8 | Active D (after pair renaming) |
| reg_e | output | 8 | Active E (after pair renaming) |
| reg_h | output | 8 | Active H (after pair renaming) |
| reg_l | output | 8 | Active L (after pair renaming) |
| alt_a | output | 8 | Reserve accumulator |
| alt_f | output | 8 | Reserve flags |
| alt_b | output | 8 | Reserve B |
| alt_c | output | 8 | Reserve C |
| alt_d | output | 8 | Reserve D (after its own pair renaming) |
| alt_e | output | 8 | Reserve E (after its own pair renaming) |
| alt_h | output | 8 | Reserve H (after its own pair renaming) |
| alt_l | output | 8 | Reserve L (after its own pair renaming) |

## Verification
The bench builds the block at its default data width of 8. At that width every increment operand from 0x00 to 0xFF can be swept, which covers the 0x7F overflow and 0xFF wrap points, and so can all 256 opcodes and all 64 move field pairs. A copy-based reference model, which physically swaps values where the design only flips select bits, is then compared on all sixteen read ports after a long mixed sequence of swaps, renames, moves, increments, flag loads and idle cycles. That sequence reaches the combinations of the bank, accumulator and rename bits that a directed test would miss.

// File: rtl/dualbank_regfile.sv
module dualbank_regfile #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [7:0]   op_code,
  input  logic         flag_we,
  input  logic [W-1:0] flag_wdata,
  output logic         op_err,
  output logic [W-1:0] reg_a,
  output logic [W-1:0] reg_f,
  output logic [W-1:0] reg_b,
  output logic [W-1:0] reg_c,
  output logic [W-1:0] reg_d,
  output logic [W-1:0] reg_e,
  output logic [W-1:0] reg_h,
  output logic [W-1:0] reg_l,
  output logic [W-1:0] alt_a,
  output logic [W-1:0] alt_f,
  output logic [W-1:0] alt_b,
  output logic [W-1:0] alt_c,
  output logic [W-1:0] alt_d,
  output logic [W-1:0] alt_e,
  output logic [W-1:0] alt_h,
  output logic [W-1:0] alt_l
);
  localparam int NG    = 6;
  localparam int S_BIT = W - 1;
  localparam int Z_BIT = W - 2;
  localparam int V_BIT = 2;
  localparam logic [W-1:0] VMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [7:0] OP_NOP = 8'h00;
  localparam logic [7:0] OP_XAF = 8'h08;
  localparam logic [7:0] OP_XGP = 8'hD9;
  localparam logic [7:0] OP_XDH = 8'hEB;

  logic [W-1:0] gp  [2][NG];
  logic [W-1:0] acc [2];
  logic [W-1:0] flg [2];
  logic         gsel, asel;
  logic [1:0]   ren;

  function automatic logic [2:0] slot(input logic [2:0] c, input logic r);
    return (r && (c[2] ^ c[1])) ? (c ^ 3'b110) : c;
  endfunction

  logic [W-1:0] act_v [8];
  logic [W-1:0] alt_v [8];

  for (genvar i = 0; i < NG; i++) begin : g_view
    assign act_v[i] = gp[gsel][slot(3'(i), ren[gsel])];
    assign alt_v[i] = gp[~gsel][slot(3'(i), ren[~gsel])];
  end
  assign act_v[6] = flg[asel];
  assign act_v[7] = acc[asel];
  assign alt_v[6] = flg[~asel];
  assign alt_v[7] = acc[~asel];

  assign reg_b = act_v[0];  assign alt_b = alt_v[0];
  assign reg_c = act_v[1];  assign alt_c = alt_v[1];
  assign reg_d = act_v[2];  assign alt_d = alt_v[2];
  assign reg_e = act_v[3];  assign alt_e = alt_v[3];
  assign reg_h = act_v[4];  assign alt_h = alt_v[4];
  assign reg_l = act_v[5];  assign alt_l = alt_v[5];
  assign reg_f = act_v[6];  assign alt_f = alt_v[6];
  assign reg_a = act_v[7];  assign alt_a = alt_v[7];

  logic [2:0] dst, src;
  logic is_mov, is_inc, is_xaf, is_xgp, is_xdh, is_nop, bad;
  assign dst    = op_code[5:3];
  assign src    = op_code[2:0];
  assign is_mov = op_code[7:6] == 2'b01;
  assign is_inc = op_code[7:6] == 2'b00 && src == 3'b100;
  assign is_xaf = op_code == OP_XAF;
  assign is_xgp = op_code == OP_XGP;
  assign is_xdh = op_code == OP_XDH;
  assign is_nop = op_code == OP_NOP;

  always_comb begin
    if (is_mov)      bad = (dst == 3'd6) || (src == 3'd6);
    else if (is_inc) bad = (dst == 3'd6);
    else             bad = !(is_xaf || is_xgp || is_xdh || is_nop);
  end

  logic         go;
  logic [W-1:0] opnd, sum, wval, fnew;
  assign go   = op_valid && !bad;
  assign opnd = act_v[dst];
  assign sum  = opnd + 1'b1;
  assign wval = is_mov ? act_v[src] : sum;

  always_comb begin
    fnew        = flg[asel];
    fnew[S_BIT] = sum[W-1];
    fnew[Z_BIT] = (sum == '0);
    fnew[V_BIT] = (opnd == VMAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++) begin
        for (int i = 0; i < NG; i++) gp[b][i] <= '0;
        acc[b] <= '0;
        flg[b] <= '0;
      end
      gsel   <= 1'b0;
      asel   <= 1'b0;
      ren    <= '0;
      op_err <= 1'b0;
    end else begin
      op_err <= op_valid && bad;
      if (go && (is_mov || is_inc)) begin
        if (dst == 3'd7) acc[asel] <= wval;
        else             gp[gsel][slot(dst, ren[gsel])] <= wval;
      end
      if (go && is_inc)              flg[asel] <= fnew;
      else if (!op_valid && flag_we) flg[asel] <= flag_wdata;
      if (go && is_xaf) asel <= ~asel;
      if (go && is_xgp) gsel <= ~gsel;
      if (go && is_xdh) ren[gsel] <= ~ren[gsel];
    end
  end
endmodule

// File: rtl/dualbank_regfile_chk.sv
module dualbank_regfile_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [7:0]   op_code,
  input logic         flag_we,
  input logic [W-1:0] flag_wdata,
  input logic         op_err,
  input logic [W-1:0] reg_a, reg_f, reg_b, reg_c, reg_d, reg_e, reg_h, reg_l,
  input logic [W-1:0] alt_a, alt_f, alt_b, alt_c, alt_d, alt_e, alt_h, alt_l
);
  logic [6*W-1:0] gp_act, gp_alt;
  logic [2*W-1:0] af_act, af_alt;
  logic [1:0]     dh_inc_guard;
  assign gp_act = {reg_b, reg_c, reg_d, reg_e, reg_h, reg_l};
  assign gp_alt = {alt_b, alt_c, alt_d, alt_e, alt_h, alt_l};
  assign af_act = {reg_a, reg_f};
  assign af_alt = {alt_a, alt_f};
  assign dh_inc_guard = {op_code[5:3] != 3'd6, op_code[7:6] == 2'b00 && op_code[2:0] == 3'd4};

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (gp_act == '0 && gp_alt == '0 && af_act == '0 && af_alt == '0 && !op_err)); // R1

  AST_GP_SWAP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 8'hD9) |=> (gp_act == $past(gp_alt) && gp_alt == $past(gp_act) && af_act == $past(af_act))); // R3

  AST_AF_SWAP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 8'h08) |=> (af_act == $past(af_alt) && af_alt == $past(af_act) && gp_act == $past(gp_act))); // R4

  AST_PAIR_SWAP: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 8'hEB) |=> (reg_d == $past(reg_h) && reg_e == $past(reg_l) && reg_h == $past(reg_d)
      && reg_l == $past(reg_e) && gp_alt == $past(gp_alt))); // R5

  AST_INC_KEEP_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && dh_inc_guard == 2'b11) |=> (reg_f[0] == $past(reg_f[0]))); // R7

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    op_err |-> (gp_act == $past(gp_act) && gp_alt == $past(gp_alt) && af_act == $past(af_act) && af_alt == $past(af_alt))); // R8

  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && flag_we) |=> (reg_f == $past(flag_wdata))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !flag_we) |=> (gp_act == $past(gp_act) && af_act == $past(af_act) && gp_alt == $past(gp_alt) && af_alt == $past(af_alt))); // R10
endmodule

bind dualbank_regfile dualbank_regfile_chk #(.W(W)) u_chk (.*);

// File: tb/dualbank_regfile_test.sv
module dualbank_regfile_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [7:0] op_code = 8'h00;
  logic       flag_we = 1'b0;
  logic [7:0] flag_wdata = 8'h00;
  logic       op_err;
  logic [7:0] reg_a, reg_f, reg_b, reg_c, reg_d, reg_e, reg_h, reg_l;
  logic [7:0] alt_a, alt_f, alt_b, alt_c, alt_d, alt_e, alt_h, alt_l;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dualbank_regfile uut (.*);

  // Copy-based model: index = register code, slot 6 holds F.
  logic [7:0] m_act [8];
  logic [7:0] m_alt [8];
  logic       m_err;

  task automatic m_clear();
    for (int i = 0; i < 8; i++) begin m_act[i] = 8'h00; m_alt[i] = 8'h00; end
    m_err = 1'b0;
  endtask

  function automatic bit m_legal(input logic [7:0] op);
    if (op == 8'h00 || op == 8'h08 || op == 8'hD9 || op == 8'hEB) return 1;
    if (op[7:6] == 2'b01) return (op[5:3] != 3'd6) && (op[2:0] != 3'd6);
    if (op[7:6] == 2'b00 && op[2:0] == 3'd4) return op[5:3] != 3'd6;
    return 0;
  endfunction

  task automatic m_step(input logic v, input logic [7:0] op, input logic fwe, input logic [7:0] fwd);
    logic [7:0] t, o, n, f;
    m_err = 1'b0;
    if (!v) begin
      if (fwe) m_act[6] = fwd;
    end else if (!m_legal(op)) begin
      m_err = 1'b1;
    end else if (op == 8'h08) begin
      for (int i = 6; i < 8; i++) begin t = m_act[i]; m_act[i] = m_alt[i]; m_alt[i] = t; end
    end else if (op == 8'hD9) begin
      for (int i = 0; i < 6; i++) begin t = m_act[i]; m_act[i] = m_alt[i]; m_alt[i] = t; end
    end else if (op == 8'hEB) begin
      t = m_act[2]; m_act[2] = m_act[4]; m_act[4] = t;
      t = m_act[3]; m_act[3] = m_act[5]; m_act[5] = t;
    end else if (op[7:6] == 2'b01) begin
      m_act[op[5:3]] = m_act[op[2:0]];
    end else if (op[7:6] == 2'b00 && op[2:0] == 3'd4) begin
      o = m_act[op[5:3]];
      n = o + 8'd1;
      m_act[op[5:3]] = n;
      f = m_act[6];
      f[7] = n[7];
      f[6] = (n == 8'h00);
      f[2] = (o == 8'h7F);
      m_act[6] = f;
    end
  endtask

  task automatic chk(input string tag, input string nm, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, nm, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, "A", reg_a, m_act[7]);      chk(tag, "F", reg_f, m_act[6]);
    chk(tag, "B", reg_b, m_act[0]);      chk(tag, "C", reg_c, m_act[1]);
    chk(tag, "D", reg_d, m_act[2]);      chk(tag, "E", reg_e, m_act[3]);
    chk(tag, "H", reg_h, m_act[4]);      chk(tag, "L", reg_l, m_act[5]);
    chk(tag, "A'", alt_a, m_alt[7]);     chk(tag, "F'", alt_f, m_alt[6]);
    chk(tag, "B'", alt_b, m_alt[0]);     chk(tag, "C'", alt_c, m_alt[1]);
    chk(tag, "D'", alt_d, m_alt[2]);     chk(tag, "E'", alt_e, m_alt[3]);
    chk(tag, "H'", alt_h, m_alt[4]);     chk(tag, "L'", alt_l, m_alt[5]);
    chk(tag, "err", {7'd0, op_err}, {7'd0, m_err});
  endtask

  // One cycle: inputs set at a falling edge, result sampled at the next falling edge (R11).
  task automatic step(input logic v, input logic [7:0] op, input logic fwe, input logic [7:0] fwd, input string tag);
    @(negedge clk);
    op_valid = v; op_code = op; flag_we = fwe; flag_wdata = fwd;
    @(negedge clk);
    op_valid = 1'b0; flag_we = 1'b0;
    m_step(v, op, fwe, fwd);
    chk_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_clear();
    chk_all("R1");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_clear();
    do_reset();

    // R9: flag load, then flag write ignored during a valid op
    step(1'b0, 8'hD9, 1'b1, 8'h3B, "R9");
    step(1'b1, 8'h00, 1'b1, 8'hA5, "R9");
    // R10: opcodes ignored while op_valid is low
    step(1'b0, 8'hD9, 1'b0, 8'h00, "R10");
    step(1'b0, 8'h3C, 1'b0, 8'h00, "R10");

    // R6/R7: sweep every operand value through the accumulator (0x7F and 0xFF included)
    for (int k = 0; k < 256; k++) step(1'b1, 8'h3C, 1'b0, 8'h00, "R7");
    // R6: give each general register a distinct value
    for (int r = 0; r < 6; r++)
      for (int k = 0; k <= 3 * r + 1; k++) step(1'b1, {2'b00, 3'(r), 3'b100}, 1'b0, 8'h00, "R6");
    step(1'b1, 8'hD9, 1'b0, 8'h00, "R3");
    for (int r = 0; r < 6; r++)
      for (int k = 0; k <= 2 * r + 5; k++) step(1'b1, {2'b00, 3'(r), 3'b100}, 1'b0, 8'h00, "R6");
    step(1'b1, 8'h08, 1'b0, 8'h00, "R4");
    step(1'b1, 8'h3C, 1'b0, 8'h00, "R6");
    step(1'b1, 8'hEB, 1'b0, 8'h00, "R5");
    step(1'b1, 8'hD9, 1'b0, 8'h00, "R5");
    step(1'b1, 8'hD9, 1'b0, 8'h00, "R5");

    // R2/R8: every move field pair, with a mixing increment between moves
    for (int d = 0; d < 8; d++)
      for (int s = 0; s < 8; s++) begin
        step(1'b1, {2'b01, 3'(d), 3'(s)}, 1'b0, 8'h00, ((d == 6) || (s == 6)) ? "R8" : "R2");
        step(1'b1, {2'b00, 3'(s == 6 ? 7 : s), 3'b100}, 1'b0, 8'h00, "R6");
      end

    // R8: every opcode once
    for (int op = 0; op < 256; op++) begin
      step(1'b1, 8'(op), 1'b0, 8'h00, m_legal(8'(op)) ? "R11" : "R8");
      step(1'b1, 8'h04 | {2'b00, 3'(op % 6), 3'b000}, 1'b0, 8'h00, "R6");
    end

    // Mixed sequence against the copy-based model
    for (int n = 0; n < 3000; n++) begin
      int cls;
      logic v, fwe;
      logic [7:0] op;
      string tag;
      cls = int'($urandom % 8);
      v   = ($urandom % 6) != 0;
      fwe = ($urandom % 4) == 0;
      case (cls)
        0, 1: begin op = {2'b00, 3'($urandom % 8), 3'b100}; tag = "R6"; end
        2, 3: begin op = {2'b01, 6'($urandom)};            tag = "R2"; end
        4:    begin op = 8'hD9;                             tag = "R3"; end
        5:    begin op = 8'h08;                             tag = "R4"; end
        6:    begin op = 8'hEB;                             tag = "R5"; end
        default: begin op = 8'($urandom);                   tag = "R8"; end
      endcase
      if (!v) tag = fwe ? "R9" : "R10";
      step(v, op, fwe, 8'($urandom), tag);
    end

    do_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule